// File: doc/BRIEF.md
# Reset Configuration Word Capture

This block holds the 32-bit configuration word that the rest of a device reads when it comes out of hard reset. A word is loaded by a short active-low pulse on an asynchronous strobe pin while the data bus carries the word. The capture point is the pulse's trailing (rising) edge. A pulse counts only inside a reset window, meaning the hard reset is asserted and power-on reset is not.

Three outcomes follow from this. If the strobe pin is tied high, no pulse ever arrives and the word stays at its all-zero default. A boot master can strobe in a word during the hard reset that follows power-on. A board without a boot master can have an external agent pulse the strobe once after power-on reset. A word loaded this way is kept through every later hard reset until the next power-on reset.

The strobe, the data bus and the window qualifier go through the same synchronizer pipeline, so they stay aligned. With `SYNC_STAGES` stages, suppose the strobe is first seen high at clock edge k. The word then changes at edge k+`SYNC_STAGES`. Power-on and hard reset are synchronous, active-high inputs.

Top module: `rst_cfg_latch`

## Requirements
- R1: While power-on reset (`por_i`) is high, the configuration word is cleared to all zeros at each clock edge.
- R2: If the strobe stays high through power-on reset and the following hard reset, the configuration word stays all zeros.
- R3: Suppose the strobe, after being low, is first sampled high at edge k while `hrst_i`=1 and `por_i`=0. Then the word sampled on `cfg_data_i` at edge k appears on `cfg_word_o` at edge k+`SYNC_STAGES` (edge k+2 by default).
- R4: A strobe pulse whose rising edge is sampled while `hrst_i` is low leaves the word unchanged.
- R5: A strobe pulse whose rising edge is sampled while `por_i` is high leaves the word at zero.
- R6: A later hard reset with no strobe pulse keeps the previously captured word and does not return it to zero.
- R7: If several pulses arrive inside one reset window, the word from the last pulse is kept.
- R8: A pulse in a later hard reset window replaces an earlier captured word.
- R9: If the strobe goes low inside a window but rises only after `hrst_i` has dropped, the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| hrst_i | input | 1 | Hard reset, synchronous, active high; opens the capture window |
| cfg_strobe_n_i | input | 1 | Asynchronous active-low load strobe; capture on its rising edge |
| cfg_data_i | input | 32 | Configuration word presented during the strobe pulse |
| cfg_word_o | output | 32 | Registered configuration word |

## Verification
The assertions assume that `por_i` and `hrst_i` are synchronous to `clk_i` and that power-on reset is high at the first clock edge. They also assume that `cfg_data_i` holds steady from the falling edge of the strobe until a few cycles after its rising edge, so that the sampled word is well defined. The stimulus drives all inputs on the falling clock edge and changes the data bus only while the strobe is high and no rise is in the pipeline. Every strobe pulse lasts several cycles, so each edge is seen by the synchronizer.

// File: rtl/rst_cfg_pkg.sv
package rst_cfg_pkg;
  localparam int unsigned CFG_W = 32;
  typedef logic [CFG_W-1:0] cfg_word_t;
endpackage

// File: rtl/cfg_sync_pipe.sv
module cfg_sync_pipe #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[0] <= RST_VAL;
        else       stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge_detect.sv
module cfg_edge_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strb_i,
  input  logic win_i,
  output logic cap_o
);
  logic strb_prev;

  always_ff @(posedge clk_i) begin
    if (rst_i) strb_prev <= 1'b1;
    else       strb_prev <= strb_i;
  end

  assign cap_o = strb_i & ~strb_prev & win_i;

  // R3: a trailing edge yields exactly one capture cycle
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    cap_o |=> !cap_o);
endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store
  import rst_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      por_i,
  input  logic      cap_i,
  input  cfg_word_t data_i,
  output cfg_word_t word_o
);
  logic loaded;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      word_o <= '0;
      loaded <= 1'b0;
    end else if (cap_i) begin
      word_o <= data_i;
      loaded <= 1'b1;
    end
  end

  // R1: leaving power-on reset, the word is the zero default
  a_r1_por_clear: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |-> word_o == '0);
  // R2: without any capture the word stays zero
  a_r2_zero_unloaded: assert property (@(posedge clk_i) disable iff (por_i)
    !loaded |-> word_o == '0);
  // R3: a capture lands the sampled word
  a_r3_load: assert property (@(posedge clk_i) disable iff (por_i)
    cap_i |=> (word_o == $past(data_i)) && loaded);
  // R6: no capture, no change
  a_r6_hold: assert property (@(posedge clk_i) disable iff (por_i)
    !cap_i |=> $stable(word_o));
endmodule

// File: rtl/rst_cfg_latch.sv
module rst_cfg_latch
  import rst_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             hrst_i,
  input  logic             cfg_strobe_n_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic [CFG_W-1:0] cfg_word_o
);
  logic      win_raw;
  logic      strb_s;
  logic      win_s;
  cfg_word_t data_s;
  logic      cap;

  assign win_raw = hrst_i & ~por_i;

  cfg_sync_pipe #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk_i(clk_i), .rst_i(por_i), .d_i(cfg_strobe_n_i), .q_o(strb_s));

  cfg_sync_pipe #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_win_sync (
    .clk_i(clk_i), .rst_i(por_i), .d_i(win_raw), .q_o(win_s));

  cfg_sync_pipe #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i(clk_i), .rst_i(por_i), .d_i(cfg_data_i), .q_o(data_s));

  cfg_edge_detect u_edge (
    .clk_i(clk_i), .rst_i(por_i), .strb_i(strb_s), .win_i(win_s), .cap_o(cap));

  cfg_word_store u_store (
    .clk_i(clk_i), .por_i(por_i), .cap_i(cap), .data_i(data_s), .word_o(cfg_word_o));

  // R4/R5: a capture always traces back to an open window
  a_r4_window_only: assert property (@(posedge clk_i) disable iff (por_i)
    cap |-> win_s);
endmodule

// File: tb/rst_cfg_latch_tb.sv
module rst_cfg_latch_tb;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        hrst = 1'b1;
  logic        strb_n = 1'b1;
  logic [31:0] data = '0;
  logic [31:0] word;

  int tests = 0;
  int fails = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  rst_cfg_latch u_dut (
    .clk_i(clk), .por_i(por), .hrst_i(hrst), .cfg_strobe_n_i(strb_n),
    .cfg_data_i(data), .cfg_word_o(word));

  // behavioural reference: history of samples, newest first
  typedef struct { bit s; bit w; logic [31:0] d; } smp_t;
  smp_t hist[$];
  logic [31:0] exp_word = '0;

  function automatic smp_t idle_smp();
    smp_t x; x.s = 1'b1; x.w = 1'b0; x.d = '0; return x;
  endfunction

  always @(posedge clk) begin
    smp_t n;
    if (por) begin
      exp_word = '0;
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back(idle_smp());
    end else begin
      if (hist[1].s && !hist[2].s && hist[1].w) exp_word = hist[1].d;
      n.s = strb_n; n.w = hrst && !por; n.d = data;
      hist.push_front(n);
      void'(hist.pop_back());
    end
  end

  // every-cycle comparison on the falling edge
  always @(negedge clk) begin
    tests++;
    if (word !== exp_word) begin
      fails++;
      $display("FAIL %s cycle compare: actual %h expected %h", phase, word, exp_word);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] expv);
    tests++;
    if (word !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, word, expv);
    end
  endtask

  task automatic pulse(logic [31:0] v);
    data = v;
    tick(1);
    strb_n = 1'b0;
    tick(4);
    strb_n = 1'b1;
    tick(5);
  endtask

  initial begin
    fork
      begin
        tick(3);
        check("R1", 32'h0);
        phase = "R5";
        pulse(32'hDEAD_0001);            // R5: pulse inside power-on reset
        check("R5", 32'h0);
        phase = "R2";
        por = 1'b0;                       // hard reset still asserted
        tick(10);
        hrst = 1'b0;
        tick(3);
        check("R2", 32'h0);
        phase = "R4";
        pulse(32'hA5A5_5A5A);            // R4: outside the window
        check("R4", 32'h0);
        phase = "R3";
        hrst = 1'b1;
        data = 32'h1234_5678;
        tick(1);
        strb_n = 1'b0;
        tick(3);
        strb_n = 1'b1;                    // first sampled high at next edge k
        tick(2);                          // after edges k, k+1
        check("R3 before latency", 32'h0);
        tick(1);                          // after edge k+2
        check("R3", 32'h1234_5678);
        tick(3);
        hrst = 1'b0;
        tick(3);
        phase = "R6";
        hrst = 1'b1;
        tick(8);
        hrst = 1'b0;
        tick(3);
        check("R6", 32'h1234_5678);
        phase = "R7";
        hrst = 1'b1;
        pulse(32'h0BAD_F00D);
        pulse(32'hC0FF_EE01);
        hrst = 1'b0;
        tick(3);
        check("R7", 32'hC0FF_EE01);
        phase = "R9";
        hrst = 1'b1;
        data = 32'h7777_0000;
        tick(1);
        strb_n = 1'b0;
        tick(3);
        hrst = 1'b0;
        tick(2);
        strb_n = 1'b1;
        tick(5);
        check("R9", 32'hC0FF_EE01);
        phase = "R8";
        hrst = 1'b1;
        pulse(32'hFFFF_FFFF);
        hrst = 1'b0;
        tick(3);
        check("R8", 32'hFFFF_FFFF);
        phase = "R1";
        por = 1'b1;
        hrst = 1'b1;
        tick(2);
        check("R1 second power-on", 32'h0);
        por = 1'b0;
        phase = "R3";
        pulse(32'h0000_00FF);
        hrst = 1'b0;
        tick(3);
        check("R3 after second power-on", 32'h0000_00FF);
      end
      begin
        repeat (5000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule